// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two processor request outputs: a fast-interrupt request driven only by line 0, and a normal-interrupt request driven by lines 1 and up. Each normal line carries a 3-bit priority and a handler address. Each line, line 0 included, carries its own choice of level or rising-edge detection. Software programs all of this through a single-cycle register port with separate write and read strobes.

When the normal request is raised, the handler reads the vector port. The read returns the handler address of the winning line and pushes that line's priority onto an in-service stack. The winner is the highest priority, with ties going to the lowest line number. From then on, only a strictly higher priority raises the normal request again, so handlers nest. A write to the end-of-service address pops the stack. A vector read that finds nothing able to preempt returns a programmable default value and leaves the stack alone.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A synchronous reset clears all enables, edge-pending bits, modes, vectors, the default vector and the in-service stack, and drives `irq_o`, `fiq_o` and `bus_rdata` low. After reset, no active input raises a request until that line is enabled.
- R2: Line 0 never takes part in vector arbitration. `fiq_o` is high in the cycle after line 0 is enabled and requesting. A request on line 0 alone never raises `irq_o`.
- R3: `irq_o` is registered. One cycle after the inputs, it is high exactly when some enabled, requesting line from 1 upward has a priority strictly above the top of the in-service stack, or the stack is empty.
- R4: A read at address 0x45 returns, in `bus_rdata` on the next cycle, the vector of the winning line. The winner has the highest priority, and among equal priorities the lowest line number wins.
- R5: A vector read that returns a handler address pushes the winner's priority onto the 8-deep stack. A request of equal or lower priority then waits until that level is popped.
- R6: A write to address 0x43 pops one stack entry. When the stack is empty, the write has no effect.
- R7: A write to address 0x00+n sets the mode of line n. Bits [2:0] hold the priority (7 highest) and bit 3 selects rising-edge detection (1) or level detection (0).
- R8: A write to address 0x20+n sets the vector of line n, and a write to 0x44 sets the default vector. A vector read that finds no line able to preempt returns the default vector and leaves the stack unchanged. `bus_rdata` is zero in every cycle that does not follow a vector read.
- R9: Writes to 0x40 (enable), 0x41 (disable) and 0x42 (clear pending) act on each line whose data bit is 1 and leave every line whose bit is 0 untouched.
- R10: For an edge-mode line, a rising input latches a pending bit even while the line is disabled. The bit stays set after the input falls. It is cleared by the clear command or by a vector read that selects the line. A new edge in the same cycle as a clear wins.
- R11: For a level-mode line, the request follows the input, and a vector read does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt request lines, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (only 0x45 has an effect) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | VEC_W | Write data |
| bus_rdata | output | VEC_W | Registered read data |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request from line 0, registered |

## Verification
Directed sequences cover several cases, each chosen to tell one behaviour apart from another:
- Two equal-priority level lines separate the tie rule from plain priority order.
- A higher-priority edge line arriving during service shows strict preemption, and an equal-priority line shows waiting.
- An empty-stack end-of-service write and a read with nothing eligible expose the stack-underflow and default-vector paths.
- Pulsed edge lines that fall before service separate latching from level following.
- A clear issued together with a fresh edge shows which of the two wins.

After the directed part, random toggling of inputs mixed with random mode, enable, clear, read and end-of-service traffic is compared cycle by cycle against a bench model. This exercises deep nesting and mode changes on lines that are already pending.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] A_VEC  = 8'h20;
    localparam logic [ADDR_W-1:0] A_EN   = 8'h40;
    localparam logic [ADDR_W-1:0] A_DIS  = 8'h41;
    localparam logic [ADDR_W-1:0] A_CLR  = 8'h42;
    localparam logic [ADDR_W-1:0] A_EOI  = 8'h43;
    localparam logic [ADDR_W-1:0] A_SPUR = 8'h44;
    localparam logic [ADDR_W-1:0] A_VRD  = 8'h45;
    localparam int MODE_EDGE_BIT = 3;
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
    import pic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NSRC-1:0]              src_i,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [VEC_W-1:0]             wdata,
    input  logic [NSRC-1:0]              ack_i,
    output logic [NSRC-1:0]              req_q_o,
    output logic [NSRC-1:0]              req_d_o,
    output logic [NSRC-1:0][PRIO_W-1:0]  prio_q_o,
    output logic [NSRC-1:0][PRIO_W-1:0]  prio_d_o,
    output logic [NSRC-1:0][VEC_W-1:0]   vec_o
);
    typedef struct packed {
        logic [NSRC-1:0]             en;
        logic [NSRC-1:0]             edg;
        logic [NSRC-1:0]             pend;
        logic [NSRC-1:0]             prev;
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NSRC-1:0][VEC_W-1:0]  vec;
    } bank_t;

    bank_t s_d, s_q;
    logic [NSRC-1:0] rise, clr;

    always_comb begin
        s_d  = s_q;
        rise = src_i & ~s_q.prev;
        clr  = '0;
        s_d.prev = src_i;
        if (wr_en) begin
            if (addr == A_EN)  s_d.en = s_q.en | wdata[NSRC-1:0];
            if (addr == A_DIS) s_d.en = s_q.en & ~wdata[NSRC-1:0];
            if (addr == A_CLR) clr    = wdata[NSRC-1:0];
            for (int i = 0; i < NSRC; i++) begin
                if (addr == ADDR_W'(A_MODE + i)) begin
                    s_d.prio[i] = wdata[PRIO_W-1:0];
                    s_d.edg[i]  = wdata[MODE_EDGE_BIT];
                end
                if (addr == ADDR_W'(A_VEC + i)) s_d.vec[i] = wdata;
            end
        end
        // a fresh edge outranks a clear or an acknowledge in the same cycle
        s_d.pend = ((s_q.pend & ~clr & ~ack_i) | rise) & s_d.edg;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign req_q_o  = s_q.en & ((s_q.edg & s_q.pend) | (~s_q.edg & src_i));
    assign req_d_o  = s_d.en & ((s_d.edg & s_d.pend) | (~s_d.edg & src_i));
    assign prio_q_o = s_q.prio;
    assign prio_d_o = s_d.prio;
    assign vec_o    = s_q.vec;

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        // R10
        clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == A_CLR && wdata[g] && !(src_i[g] && !s_q.prev[g]))
            |=> !s_q.pend[g]);
        // R10
        edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
            (s_d.edg[g] && src_i[g] && !s_q.prev[g]) |=> s_q.pend[g]);
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             req,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                        valid,
    output logic [IDX_W-1:0]            idx,
    output logic [PRIO_W-1:0]           win_prio
);
    // scan downward; ">=" lets the lower number take a tie
    always_comb begin
        valid    = 1'b0;
        idx      = '0;
        win_prio = '0;
        for (int i = NSRC - 1; i >= 1; i--) begin
            if (req[i] && (!valid || prio[i] >= win_prio)) begin
                valid    = 1'b1;
                idx      = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic              top_valid_q,
    output logic [PRIO_W-1:0] top_prio_q,
    output logic              top_valid_d,
    output logic [PRIO_W-1:0] top_prio_d
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] slot;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push && s_q.cnt < FULL) begin
            s_d.slot[SLOT_W'(s_q.cnt)] = push_prio;
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign top_valid_q = (s_q.cnt != '0);
    assign top_prio_q  = s_q.slot[SLOT_W'(s_q.cnt - 1'b1)];
    assign top_valid_d = (s_d.cnt != '0);
    assign top_prio_d  = s_d.slot[SLOT_W'(s_d.cnt - 1'b1)];

    // R5
    push_order_chk: assert property (@(posedge clk) disable iff (rst)
        (push && s_q.cnt != '0) |-> (push_prio > top_prio_q));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (s_q.cnt < FULL));
    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && s_q.cnt == '0) |=> (s_q.cnt == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 32,
    parameter int NEST   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [VEC_W-1:0]  bus_wdata,
    output logic [VEC_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic             irq;
        logic             fiq;
        logic [VEC_W-1:0] rdata;
        logic [VEC_W-1:0] spur;
    } top_t;

    top_t s_d, s_q;

    logic [NSRC-1:0]             req_q, req_d, ack;
    logic [NSRC-1:0][PRIO_W-1:0] prio_q, prio_d;
    logic [NSRC-1:0][VEC_W-1:0]  vec;
    logic                        win_v, nx_v;
    logic [IDX_W-1:0]            win_idx, nx_idx;
    logic [PRIO_W-1:0]           win_p, nx_p;
    logic                        top_v_q, top_v_d;
    logic [PRIO_W-1:0]           top_p_q, top_p_d;
    logic                        vrd, grant_now, push, pop;

    pic_src_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_bank (
        .clk(clk), .rst(rst), .src_i(src_i), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .ack_i(ack), .req_q_o(req_q), .req_d_o(req_d),
        .prio_q_o(prio_q), .prio_d_o(prio_d), .vec_o(vec)
    );

    // present-state winner, used by the vector read
    pic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb_now (
        .req(req_q), .prio(prio_q), .valid(win_v), .idx(win_idx), .win_prio(win_p)
    );

    // next-state winner, used to register the request output
    pic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb_nxt (
        .req(req_d), .prio(prio_d), .valid(nx_v), .idx(nx_idx), .win_prio(nx_p)
    );

    pic_nest_stack #(.DEPTH(NEST), .PRIO_W(PRIO_W)) u_stack (
        .clk(clk), .rst(rst), .push(push), .push_prio(win_p), .pop(pop),
        .top_valid_q(top_v_q), .top_prio_q(top_p_q),
        .top_valid_d(top_v_d), .top_prio_d(top_p_d)
    );

    always_comb begin
        s_d       = s_q;
        vrd       = bus_rd && bus_addr == A_VRD;
        pop       = bus_wr && bus_addr == A_EOI;
        grant_now = win_v && (!top_v_q || win_p > top_p_q);
        push      = vrd && grant_now;
        ack       = '0;
        if (push) ack[win_idx] = 1'b1;
        if (bus_wr && bus_addr == A_SPUR) s_d.spur = bus_wdata;
        s_d.rdata = vrd ? (grant_now ? vec[win_idx] : s_q.spur) : '0;
        s_d.irq   = nx_v && (!top_v_d || nx_p > top_p_d);
        s_d.fiq   = req_d[0];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;
    assign irq_o     = s_q.irq;
    assign fiq_o     = s_q.fiq;

    // R8
    spur_read_chk: assert property (@(posedge clk) disable iff (rst)
        (vrd && !win_v) |=> (bus_rdata == $past(s_q.spur)));
    // R2
    fiq_alone_chk: assert property (@(posedge clk) disable iff (rst)
        (req_d == NSRC'(1)) |=> (fiq_o && !irq_o));
    // R4
    win_req_chk: assert property (@(posedge clk) disable iff (rst)
        win_v |-> req_q[win_idx]);
    // R3
    nxt_tie_chk: assert property (@(posedge clk) disable iff (rst)
        nx_v |-> (req_d[nx_idx] && nx_idx != '0));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // bench model
    bit [31:0] m_en, m_edg, m_pend, m_prev;
    bit [2:0]  m_prio [32];
    bit [31:0] m_vec  [32];
    bit [31:0] m_spur;
    bit [2:0]  m_stk  [8];
    int        m_cnt;
    bit [31:0] e_rd;

    function automatic bit [31:0] m_req();
        return m_en & ((m_edg & m_pend) | (~m_edg & src));
    endfunction

    function automatic bit m_grant(output int idx);
        bit [31:0] r = m_req();
        bit v = 0;
        int p = 0;
        idx = 0;
        for (int i = 31; i >= 1; i--)
            if (r[i] && (!v || int'(m_prio[i]) >= p)) begin
                v = 1; idx = i; p = int'(m_prio[i]);
            end
        return v && (m_cnt == 0 || p > int'(m_stk[m_cnt-1]));
    endfunction

    task automatic m_reset();
        m_en = 0; m_edg = 0; m_pend = 0; m_prev = 0; m_spur = 0; m_cnt = 0; e_rd = 0;
        for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_vec[i] = 0; end
    endtask

    task automatic m_update(input bit wr, input bit rd, input bit [7:0] a, input bit [31:0] d);
        bit [31:0] clr = 0, ack = 0, rise;
        bit pushed = 0;
        int idx;
        e_rd = 0;
        if (rd && a == 8'h45) begin
            if (m_grant(idx)) begin
                e_rd = m_vec[idx]; ack[idx] = 1; pushed = 1;
                m_stk[m_cnt] = m_prio[idx]; m_cnt++;
            end else e_rd = m_spur;
        end
        if (wr) begin
            if (a < 8'h20) begin m_prio[a] = d[2:0]; m_edg[a] = d[3]; end
            else if (a < 8'h40) m_vec[a-8'h20] = d;
            else if (a == 8'h40) m_en |= d;
            else if (a == 8'h41) m_en &= ~d;
            else if (a == 8'h42) clr = d;
            else if (a == 8'h43 && !pushed && m_cnt > 0) m_cnt--;
            else if (a == 8'h44) m_spur = d;
        end
        rise = src & ~m_prev;
        m_prev = src;
        m_pend = ((m_pend & ~clr & ~ack) | rise) & m_edg;
    endtask

    task automatic check(input string tag, input string what, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit wr, input bit rd, input bit [7:0] a,
                        input bit [31:0] d, input bit [31:0] s);
        int idx;
        bit g;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; src = s;
        @(posedge clk);
        m_update(wr, rd, a, d);
        #2;
        g = m_grant(idx);
        check(tag, "irq_o", 32'(irq_o), 32'(g));
        check(tag, "fiq_o", 32'(fiq_o), 32'(m_en[0] & ((m_edg[0] & m_pend[0]) | (~m_edg[0] & src[0]))));
        check(tag, "bus_rdata", bus_rdata, e_rd);
    endtask

    task automatic wr(input string tag, input bit [7:0] a, input bit [31:0] d);
        step(tag, 1, 0, a, d, src);
    endtask
    task automatic rdv(input string tag);
        step(tag, 0, 1, 8'h45, 0, src);
    endtask
    task automatic srcset(input string tag, input bit [31:0] s);
        step(tag, 0, 0, 0, 0, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        check("R1", "irq_o", 32'(irq_o), 0);
        check("R1", "fiq_o", 32'(fiq_o), 0);
        check("R1", "bus_rdata", bus_rdata, 0);
        srcset("R1", 32'hFFFF_FFFF);
        rdv("R1");
        srcset("R1", 0);
        // R7 R8 programming
        for (int i = 0; i < 32; i++) begin
            wr("R8", 8'h20 + 8'(i), 32'h1000 + 32'(i));
        end
        wr("R8", 8'h44, 32'hDEAD_0000);
        wr("R7", 8'h01, 32'h3);
        wr("R7", 8'h02, 32'h3);
        wr("R7", 8'h03, 32'hD);     // edge, priority 5
        wr("R7", 8'h04, 32'h3);
        wr("R9", 8'h40, 32'h0000_0006);
        // R4 tie between lines 1 and 2
        srcset("R4", 32'h6);
        rdv("R4");
        // R5 equal priority waits; R8 default vector
        srcset("R5", 32'h6);
        rdv("R8");
        // R10 edge on line 3 while disabled, then enable
        srcset("R10", 32'hE);
        srcset("R10", 32'h6);
        wr("R9", 8'h40, 32'h8);
        rdv("R5");
        wr("R6", 8'h43, 0);
        wr("R6", 8'h43, 0);
        wr("R6", 8'h43, 0);
        rdv("R11");
        wr("R6", 8'h43, 0);
        // R10 clear, and edge beating clear
        srcset("R10", 32'hE);
        srcset("R10", 32'h6);
        wr("R10", 8'h42, 32'h8);
        step("R10", 1, 0, 8'h42, 32'h8, 32'hE);
        srcset("R10", 32'h6);
        // R9 zero bits have no effect, disable acts on one line
        wr("R9", 8'h41, 32'h0);
        wr("R9", 8'h41, 32'h2);
        rdv("R9");
        wr("R6", 8'h43, 0);
        // R2 fast line
        wr("R9", 8'h40, 32'h1);
        srcset("R2", 32'h1);
        rdv("R2");
        srcset("R2", 32'h0);
        // R3 R4 R5 R6 R7 R9 R10 R11 random traffic
        for (int n = 0; n < 5000; n++) begin
            int op = int'($urandom_range(0, 9));
            bit [31:0] s = src;
            case (op)
                0, 1: begin
                    s ^= 32'(1) << $urandom_range(0, 31);
                    srcset("R3", s);
                end
                2: wr("R7", 8'($urandom_range(0, 31)), $urandom & 32'hF);
                3: wr("R9", 8'h40, $urandom);
                4: wr("R9", 8'h41, $urandom & $urandom & $urandom);
                5: wr("R10", 8'h42, $urandom & $urandom);
                6, 7: rdv("R4");
                8: wr("R6", 8'h43, 0);
                default: wr("R8", 8'h20 + 8'($urandom_range(0, 31)), $urandom);
            endcase
        end
        finish_run();
    end
endmodule